// File: doc/BRIEF.md
# Sampled Converter Output Pipeline with Overrange Flag

This block is the digital output stage of a pipelined 16-bit converter. A raw conversion result arrives on a plain input port every clock period. It is captured on the falling clock edge and then carried through a chain of rising-edge registers. Each word reaches the parallel output bus a fixed 5.5 clock periods after the falling edge that captured it.

Next to every output word the block presents an active-high flag. The flag marks codes that sit in the clipping zone at either end of an offset-binary scale. The flag is registered in the same cycle as the word it describes, so the two always belong together. A valid bit travels with each word, so downstream logic can ignore the mid-scale filler that comes out while the pipeline refills after reset.

High impedance cannot be built inside programmable fabric, so the block does not tri-state its outputs. It passes its output-enable input straight through as a drive-enable signal placed beside the data ports. The I/O ring uses that signal to float the data and flag pins.

Top module: `adc_out_pipe`

## Requirements
- R1: The input sample is taken at the falling clock edge. A change on `smp_in` between that falling edge and the following rising edge has no effect on the word that later appears on `dout`.
- R2: A sample captured at a falling edge appears on `dout` right after the sixth rising edge that follows it, which is 5.5 clock periods later. A new sample is accepted every period, and none is dropped or repeated.
- R3: The word is passed through unchanged, in offset-binary form. Bit 15 is the MSB and bit 0 is the LSB, and no bit is reordered or inverted.
- R4: `ovr` is 1 whenever `dout` is 16'hFC00 or higher. Both 16'hFC00 and 16'hFFFF raise the flag.
- R5: `ovr` is 1 whenever `dout` is 16'h03FF or lower. Both 16'h03FF and 16'h0000 raise the flag.
- R6: `ovr` is 0 for every code from 16'h0400 to 16'hFBFF. The flag changes in the same cycle as the `dout` word it describes.
- R7: `drv_en` equals `out_en` in the same cycle. Deasserting `out_en` leaves the pipeline contents and the data flow untouched.
- R8: `rst` is a synchronous, active-high reset. After a rising edge with `rst` = 1, `dout` is 16'h8000 (mid-scale), `ovr` is 0 and `word_vld` is 0. A falling edge with `rst` = 1 also loads mid-scale into the capture register.
- R9: After reset, `word_vld` stays 0 until the first word captured with `rst` = 0 reaches `dout`. That happens at the sixth rising edge after that capture. From then on `word_vld` stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; capture on the falling edge, output update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | 16 | Raw offset-binary conversion result |
| out_en | input | 1 | Output enable request, active high |
| dout | output | 16 | Delayed conversion word |
| ovr | output | 1 | Overrange flag aligned with `dout` |
| drv_en | output | 1 | Pad drive enable for `dout` and `ovr` (0 means float the pins) |
| word_vld | output | 1 | `dout` holds a word captured after reset |

## Verification
The pipeline is driven with a counting ramp and with alternating bit patterns. The ramp shows whether the word moves by exactly six rising edges, because an off-by-one stage count shifts every word against the expected history. The alternating 16'hAAAA/16'h5555 words expose any swapped, stuck or inverted bit lanes.

A run of codes placed on both sides of each overrange limit (16'hFBFF, 16'hFC00, 16'h03FF, 16'h0400, and the two extremes) separates an inclusive compare from an exclusive one. It also shows whether the flag comes out in the cycle of its own word or of a neighbouring word.

A further pattern changes the input just after each falling edge. A design that captures on the rising edge would show these values instead of the intended ones. Reset is applied both at start-up and in the middle of a stream, and the bench checks when the valid bit rises in each case.

// File: rtl/adc_out_pkg.sv
package adc_out_pkg;

  // Converter word width.
  parameter int unsigned SMP_W = 16;

  typedef logic [SMP_W-1:0] smp_t;

  // Word plus a flag telling whether it was captured after reset.
  typedef struct packed {
    logic vld;
    smp_t code;
  } tagged_smp_t;

  // Mid-scale code of an offset-binary scale.
  localparam smp_t MID_CODE = smp_t'(1) << (SMP_W - 1);

  // Contents of every pipeline register after reset.
  localparam tagged_smp_t IDLE_WORD = '{vld: 1'b0, code: MID_CODE};

endpackage

// File: rtl/adc_negcap.sv
module adc_negcap
  import adc_out_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  smp_t        smp_in,
  output tagged_smp_t cap_q
);

  // The raw sample is taken on the falling edge. The reset is also
  // applied on this edge, so the capture register starts at mid-scale.
  always_ff @(negedge clk) begin
    if (rst) begin
      cap_q <= IDLE_WORD;
    end else begin
      cap_q <= '{vld: 1'b1, code: smp_in};
    end
  end

endmodule

// File: rtl/adc_delay_line.sv
module adc_delay_line
  import adc_out_pkg::*;
#(
  parameter int unsigned DEPTH = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  tagged_smp_t din,
  output tagged_smp_t feed_q,
  output tagged_smp_t last_q
);

  localparam int unsigned LAST = DEPTH - 1;

  tagged_smp_t stg [DEPTH];

  genvar k;
  generate
    for (k = 0; k < DEPTH; k++) begin : g_stage
      if (k == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) stg[k] <= IDLE_WORD;
          else     stg[k] <= din;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst) stg[k] <= IDLE_WORD;
          else     stg[k] <= stg[k-1];
        end

        // R2
        stage_shift_chk: assert property (@(posedge clk) disable iff (rst)
          !$past(rst) |-> (stg[k] == $past(stg[k-1])));
      end
    end
  endgenerate

  // feed_q is the word that the last stage loads next. The flag logic
  // reads it so that the flag is registered together with that word.
  assign feed_q = stg[LAST-1];
  assign last_q = stg[LAST];

endmodule

// File: rtl/adc_range_det.sv
module adc_range_det
  import adc_out_pkg::*;
#(
  parameter smp_t HI_CODE = 16'hFC00,
  parameter smp_t LO_CODE = 16'h03FF
) (
  input  logic clk,
  input  logic rst,
  input  smp_t code_nxt,
  output logic flag_q
);

  logic clip_c;

  // Both limits are inclusive.
  always_comb begin
    clip_c = (code_nxt >= HI_CODE) || (code_nxt <= LO_CODE);
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= clip_c;
  end

endmodule

// File: rtl/adc_out_pipe.sv
module adc_out_pipe
  import adc_out_pkg::*;
#(
  parameter int unsigned RISE_STAGES = 6,
  parameter smp_t        HI_CODE     = 16'hFC00,
  parameter smp_t        LO_CODE     = 16'h03FF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SMP_W-1:0] smp_in,
  input  logic             out_en,
  output logic [SMP_W-1:0] dout,
  output logic             ovr,
  output logic             drv_en,
  output logic             word_vld
);

  tagged_smp_t cap_q;
  tagged_smp_t feed_q;
  tagged_smp_t last_q;
  logic        flag_q;

  adc_negcap u_cap (
    .clk    (clk),
    .rst    (rst),
    .smp_in (smp_in),
    .cap_q  (cap_q)
  );

  adc_delay_line #(.DEPTH(RISE_STAGES)) u_dly (
    .clk    (clk),
    .rst    (rst),
    .din    (cap_q),
    .feed_q (feed_q),
    .last_q (last_q)
  );

  adc_range_det #(.HI_CODE(HI_CODE), .LO_CODE(LO_CODE)) u_rng (
    .clk      (clk),
    .rst      (rst),
    .code_nxt (feed_q.code),
    .flag_q   (flag_q)
  );

  assign dout     = last_q.code;
  assign word_vld = last_q.vld;
  assign ovr      = flag_q;

  // The I/O ring uses drv_en to float the data and flag pins.
  assign drv_en   = out_en;

  // R4 R5
  flag_window_chk: assert property (@(posedge clk) disable iff (rst)
    ovr |-> ((dout >= HI_CODE) || (dout <= LO_CODE)));

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !ovr |-> ((dout < HI_CODE) && (dout > LO_CODE)));

  // R8
  reset_state_chk: assert property (@(posedge clk)
    rst |=> ((dout == MID_CODE) && !ovr && !word_vld));

  // R9
  vld_hold_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> word_vld);

endmodule

// File: tb/sim_adc_out_pipe.sv
module sim_adc_out_pipe;

  localparam int LAT = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] raw = 16'h0000;
  logic        out_en = 1'b1;
  logic [15:0] dout;
  logic        ovr;
  logic        drv_en;
  logic        word_vld;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Expected history, one entry per driven word; the entry at index
  // LAT-1 is the one that should be on the output now.
  logic [15:0] m_code [LAT];
  logic        m_vld  [LAT];

  always #4 clk = ~clk;

  adc_out_pipe u0 (
    .clk      (clk),
    .rst      (rst),
    .smp_in   (raw),
    .out_en   (out_en),
    .dout     (dout),
    .ovr      (ovr),
    .drv_en   (drv_en),
    .word_vld (word_vld)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp_v, $time);
    end
  endtask

  function automatic bit clip(input logic [15:0] c);
    return (c >= 16'hFC00) || (c <= 16'h03FF);
  endfunction

  // One clock period: compare outputs with the history, then drive the
  // next word. When glitch_on is set, the input changes just after the
  // falling edge; the captured word is still v.
  task automatic step(input logic [15:0] v, input string dreq,
                      input bit glitch_on, input logic [15:0] glitch);
    string freq;
    @(posedge clk); #1;
    chk(dout == m_code[LAT-1], dreq, dout, m_code[LAT-1]);
    chk(word_vld == m_vld[LAT-1], "R9", {15'd0, word_vld}, {15'd0, m_vld[LAT-1]});
    if (m_code[LAT-1] >= 16'hFC00)      freq = "R4";
    else if (m_code[LAT-1] <= 16'h03FF) freq = "R5";
    else                                freq = "R6";
    chk(ovr == clip(m_code[LAT-1]), freq, {15'd0, ovr}, {15'd0, clip(m_code[LAT-1])});
    for (int i = LAT-1; i > 0; i--) begin
      m_code[i] = m_code[i-1];
      m_vld[i]  = m_vld[i-1];
    end
    rst       = 1'b0;
    raw       = v;
    m_code[0] = v;
    m_vld[0]  = 1'b1;
    if (glitch_on) begin
      @(negedge clk); #1;
      raw = glitch;
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    raw = 16'hFFFF;
    repeat (3) @(posedge clk);
    #1;
    // R8
    chk(dout == 16'h8000, "R8", dout, 16'h8000);
    chk(ovr == 1'b0, "R8", {15'd0, ovr}, 16'h0000);
    chk(word_vld == 1'b0, "R8", {15'd0, word_vld}, 16'h0000);
    for (int i = 0; i < LAT; i++) begin
      m_code[i] = 16'h8000;
      m_vld[i]  = 1'b0;
    end
  endtask

  task automatic flush(input string req);
    for (int i = 0; i < LAT; i++) step(16'h8000, req, 1'b0, 16'h0);
  endtask

  task automatic t_ramp();
    // R2: a counting ramp shows the exact six-edge alignment
    for (int i = 0; i < 24; i++) step(16'h1000 + 16'(i * 257), "R2", 1'b0, 16'h0);
  endtask

  task automatic t_bits();
    // R3: alternating lanes show swapped or inverted bits
    for (int i = 0; i < 8; i++)
      step((i % 2) ? 16'hAAAA : 16'h5555, "R3", 1'b0, 16'h0);
    step(16'h0001, "R3", 1'b0, 16'h0);
    step(16'h8000, "R3", 1'b0, 16'h0);
    flush("R3");
  endtask

  task automatic t_limits();
    // R4 R5 R6: both limits and their neighbours
    step(16'hFC00, "R4", 1'b0, 16'h0);
    step(16'hFBFF, "R6", 1'b0, 16'h0);
    step(16'hFFFF, "R4", 1'b0, 16'h0);
    step(16'h03FF, "R5", 1'b0, 16'h0);
    step(16'h0400, "R6", 1'b0, 16'h0);
    step(16'h0000, "R5", 1'b0, 16'h0);
    step(16'h8000, "R6", 1'b0, 16'h0);
    step(16'hFC01, "R4", 1'b0, 16'h0);
    step(16'h03FE, "R5", 1'b0, 16'h0);
    flush("R6");
  endtask

  task automatic t_falling_edge();
    // R1: input changes after the falling edge must not reach the output
    for (int i = 0; i < 10; i++)
      step(16'h2222 + 16'(i * 4369), "R1", 1'b1, ~(16'h2222 + 16'(i * 4369)));
    flush("R1");
  endtask

  task automatic t_enable();
    // R7: drv_en follows out_en and the data flow is untouched
    out_en = 1'b0;
    #1;
    chk(drv_en == 1'b0, "R7", {15'd0, drv_en}, 16'h0000);
    for (int i = 0; i < 8; i++) begin
      step(16'h7000 + 16'(i), "R7", 1'b0, 16'h0);
      chk(drv_en == 1'b0, "R7", {15'd0, drv_en}, 16'h0000);
    end
    out_en = 1'b1;
    #1;
    chk(drv_en == 1'b1, "R7", {15'd0, drv_en}, 16'h0001);
    flush("R7");
  endtask

  task automatic t_valid_rise();
    // R9: valid must stay low for five edges and rise on the sixth
    do_reset();
    for (int i = 0; i < 8; i++) step(16'hC000 + 16'(i), "R9", 1'b0, 16'h0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_ramp();
    t_bits();
    t_limits();
    t_falling_edge();
    t_enable();
    t_valid_rise();
    t_limits();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule